// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer (Control Write)

This block runs the default control pipe of a USB device for transfers where the host writes data to the device. A packet layer, not part of this block, decodes tokens, streams the received payload bytes, flags the end of each data packet with its error status and data toggle, and reports the host's handshake after a device transmission. The sequencer chooses the handshake the device returns, which is ACK, NAK or a zero-length DATA1 packet. It keeps the eight setup bytes as decoded request fields and raises interrupts toward the CPU.

Each stage waits for the CPU before it moves on. Data-stage OUT packets are refused until the CPU acknowledges that it has seen the setup request. The status-stage IN is refused until the CPU writes the end-of-packet command. A data packet that has been taken stays marked as ready until the CPU reports that it has drained the FIFO, and any OUT packet arriving before then is refused. The payload FIFO is modelled only by the byte count of the packet that was taken.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: Synchronous active-high reset gives stage 0 (idle), data_ready 0, data_size 0, irq_flags 0, and no response or interrupt pulse.
- R2: Token codes are 0 SETUP, 1 OUT and 2 IN. A SETUP token moves the stage to 1 (setup). A following error-free packet of exactly 8 bytes is answered ACK. It also loads the fields (byte 0 to req_type, byte 1 to req_code, bytes 3:2 to req_value, 5:4 to req_index, 7:6 to req_length, high byte second), pulses irq_setup for one cycle and moves the stage to 2 (data).
- R3: A packet flagged as an error gets no response and changes no state. A setup packet that is not 8 bytes long also gets no response, and it leaves the request fields and the stage unchanged.
- R4: An error-free OUT packet gets NAK when the stage is not data, or when the setup acknowledge has not been written since the last SETUP.
- R5: In the data stage after the acknowledge, an OUT packet whose toggle matches the expected one is ACKed. It sets data_ready, sets data_size to its byte count and flips the expected toggle. The first expected toggle after a setup is DATA1.
- R6: An OUT packet with the wrong toggle is ACKed but discarded. data_ready, data_size and the expected toggle stay as they were.
- R7: While data_ready is 1, an OUT packet gets NAK. The FIFO-drained strobe clears data_ready.
- R8: An end-of-packet write with the endpoint bit at 0, in the data stage after the acknowledge, moves the stage to 3 (status). A write with the bit at 1 is ignored.
- R9: An IN token outside the status stage is answered NAK.
- R10: An IN token in the status stage is answered with a zero-length DATA1 packet. The host ACK that follows pulses irq_status and returns the stage to idle. A host ACK with no such packet sent has no effect.
- R11: A SETUP token in any stage aborts the transfer. It clears data_ready and the setup acknowledge and restarts the setup stage.
- R12: irq_flags bit 0 latches irq_setup and bit 1 latches irq_status. Writing 1 to a bit clears it. A set in the same cycle wins over the clear.
- R13: Response codes are 0 ACK, 1 NAK and 2 zero-length DATA1. A response appears on rsp_valid for one cycle after the edge that samples the token or the packet end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token code |
| rx_valid | input | 1 | Received payload byte strobe |
| rx_byte | input | 8 | Received payload byte |
| pkt_end | input | 1 | End of received data packet |
| pkt_err | input | 1 | Packet arrived with error |
| pkt_data1 | input | 1 | Packet toggle, 1 = DATA1 |
| host_ack | input | 1 | Host handshake ACK for a device packet |
| cpu_setup_ack | input | 1 | CPU write: setup request recognized |
| cpu_eop_wr | input | 1 | CPU write of end-of-packet command |
| cpu_eop_ep0 | input | 1 | Endpoint bit value of that write |
| cpu_fifo_drained | input | 1 | CPU has emptied the FIFO |
| cpu_irq_clr_wr | input | 1 | Interrupt flag clear write |
| cpu_irq_clr | input | 2 | Write-one-to-clear mask |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Response code |
| stage | output | 2 | Current stage |
| req_type | output | 8 | Request type field |
| req_code | output | 8 | Request code field |
| req_value | output | 16 | Value field |
| req_index | output | 16 | Index field |
| req_length | output | 16 | Length field |
| data_ready | output | 1 | Data packet waiting for CPU |
| data_size | output | 7 | Byte count of that packet |
| irq_setup | output | 1 | Setup interrupt pulse |
| irq_status | output | 1 | Status-done interrupt pulse |
| irq_flags | output | 2 | Latched interrupt flags |

## Verification
The bench goes after the handshake gates. It sends an OUT before the setup acknowledge, an OUT while a packet is still waiting, and an IN before the end-of-packet write, and a design that leaked any of these would answer ACK or send data early. It sends wrong-toggle packets, which a faulty design would latch as new data or use to flip the toggle. It also covers 7-byte and errored setup packets, which must leave the fields unchanged, and a host ACK with no packet sent, which must not finish the transfer. Further cases are a SETUP abort in the middle of a transfer with data waiting, an end-of-packet write with the bit at 1, and a flag clear that coincides with a new setup interrupt, where a wrong priority would lose the flag.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_DATA   = 2'd2,
        ST_STATUS = 2'd3
    } stage_t;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_NONE  = 2'd3
    } tok_t;

    typedef enum logic [1:0] {
        RS_ACK = 2'd0,
        RS_NAK = 2'd1,
        RS_ZLP = 2'd2
    } rsp_t;

    localparam int SETUP_BYTES = 8;
    localparam int SETUP_IDX_W = $clog2(SETUP_BYTES);
    localparam int NUM_IRQ     = 2;

    typedef logic [SETUP_BYTES-1:0][7:0] setup_raw_t;

    typedef struct packed {
        logic [7:0]  rtype;
        logic [7:0]  code;
        logic [15:0] value;
        logic [15:0] index;
        logic [15:0] length;
    } setup_req_t;

    function automatic setup_req_t decode_setup(input setup_raw_t b);
        setup_req_t r;
        r.rtype  = b[0];
        r.code   = b[1];
        r.value  = {b[3], b[2]};
        r.index  = {b[5], b[4]};
        r.length = {b[7], b[6]};
        return r;
    endfunction

endpackage

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture
    import ep0_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   byte_we,
    input  logic [SETUP_IDX_W-1:0] byte_idx,
    input  logic [7:0]             byte_in,
    input  logic                   commit,
    output setup_req_t             req
);

    setup_raw_t shadow;

    for (genvar i = 0; i < SETUP_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= '0;
            end else if (byte_we && byte_idx == SETUP_IDX_W'(i)) begin
                shadow[i] <= byte_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (commit) begin
            req <= decode_setup(shadow);
        end
    end

    // R3: the visible fields move only when a good setup packet commits
    a_r3_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> req == $past(req));

endmodule

// File: rtl/ep0_irq_status.sv
module ep0_irq_status
    import ep0_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set,
    input  logic               clr_wr,
    input  logic [NUM_IRQ-1:0] clr,
    output logic [NUM_IRQ-1:0] flags
);

    logic [NUM_IRQ-1:0] clr_mask;

    always_comb clr_mask = clr_wr ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set;
        end
    end

    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((flags & $past(set)) == $past(set)));

    a_r12_clear_takes: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((flags & $past(clr & ~set)) == '0));

endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import ep0_seq_pkg::*;
#(
    parameter int SIZE_W = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tok_valid,
    input  tok_t                   tok_kind,
    input  logic                   rx_valid,
    input  logic                   pkt_end,
    input  logic                   pkt_err,
    input  logic                   pkt_data1,
    input  logic                   host_ack,
    input  logic                   cpu_setup_ack,
    input  logic                   cpu_eop_wr,
    input  logic                   cpu_eop_ep0,
    input  logic                   cpu_fifo_drained,
    output logic                   rsp_valid,
    output rsp_t                   rsp_code,
    output stage_t                 stage,
    output logic                   data_ready,
    output logic [SIZE_W-1:0]      data_size,
    output logic                   setup_byte_we,
    output logic [SETUP_IDX_W-1:0] setup_byte_idx,
    output logic                   setup_commit,
    output logic                   status_done,
    output logic                   irq_setup,
    output logic                   irq_status
);

    localparam logic [SIZE_W-1:0] CNT_MAX   = '1;
    localparam logic [SIZE_W-1:0] SETUP_CNT = SIZE_W'(SETUP_BYTES);

    stage_t            stage_q;
    tok_t              last_q;
    logic [SIZE_W-1:0] cnt_q;
    logic              acked_q, ready_q, tog_q, zlp_sent_q;
    logic              rsp_v_q;
    rsp_t              rsp_q;
    logic              irq_setup_q, irq_status_q;
    logic [SIZE_W-1:0] size_q;

    logic byte_fire, end_fire, setup_ok, out_end, out_take, out_keep, eop_go;

    always_comb begin
        byte_fire     = rx_valid && !tok_valid;
        end_fire      = pkt_end && !tok_valid && !rx_valid && !pkt_err;
        setup_ok      = end_fire && last_q == TK_SETUP && stage_q == ST_SETUP
                        && cnt_q == SETUP_CNT;
        out_end       = end_fire && last_q == TK_OUT;
        out_take      = out_end && stage_q == ST_DATA && acked_q && !ready_q;
        out_keep      = out_take && (pkt_data1 == tog_q);
        eop_go        = cpu_eop_wr && !cpu_eop_ep0 && stage_q == ST_DATA && acked_q;
        status_done   = host_ack && !tok_valid && zlp_sent_q && stage_q == ST_STATUS;
        setup_byte_we = byte_fire && last_q == TK_SETUP && stage_q == ST_SETUP
                        && cnt_q < SETUP_CNT;
        setup_byte_idx = cnt_q[SETUP_IDX_W-1:0];
        setup_commit  = setup_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q      <= ST_IDLE;
            last_q       <= TK_NONE;
            cnt_q        <= '0;
            acked_q      <= 1'b0;
            ready_q      <= 1'b0;
            tog_q        <= 1'b0;
            zlp_sent_q   <= 1'b0;
            size_q       <= '0;
            rsp_v_q      <= 1'b0;
            rsp_q        <= RS_ACK;
            irq_setup_q  <= 1'b0;
            irq_status_q <= 1'b0;
        end else begin
            rsp_v_q      <= 1'b0;
            irq_setup_q  <= setup_ok;
            irq_status_q <= status_done;
            if (cpu_setup_ack && stage_q == ST_DATA) acked_q <= 1'b1;
            if (cpu_fifo_drained) ready_q <= 1'b0;
            if (eop_go) stage_q <= ST_STATUS;
            if (status_done) begin
                stage_q    <= ST_IDLE;
                zlp_sent_q <= 1'b0;
            end
            if (tok_valid) begin
                cnt_q  <= '0;
                last_q <= (tok_kind == TK_IN) ? TK_NONE : tok_kind;
                case (tok_kind)
                    TK_SETUP: begin
                        stage_q    <= ST_SETUP;
                        acked_q    <= 1'b0;
                        ready_q    <= 1'b0;
                        zlp_sent_q <= 1'b0;
                    end
                    TK_IN: begin
                        rsp_v_q <= 1'b1;
                        if (stage_q == ST_STATUS) begin
                            rsp_q      <= RS_ZLP;
                            zlp_sent_q <= 1'b1;
                        end else begin
                            rsp_q <= RS_NAK;
                        end
                    end
                    default: ;
                endcase
            end else if (rx_valid) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else if (pkt_end) begin
                last_q <= TK_NONE;
                if (setup_ok) begin
                    rsp_v_q <= 1'b1;
                    rsp_q   <= RS_ACK;
                    stage_q <= ST_DATA;
                    tog_q   <= 1'b1;
                end
                if (out_end) begin
                    rsp_v_q <= 1'b1;
                    rsp_q   <= out_take ? RS_ACK : RS_NAK;
                    if (out_keep) begin
                        ready_q <= 1'b1;
                        size_q  <= cnt_q;
                        tog_q   <= ~tog_q;
                    end
                end
            end
        end
    end

    always_comb begin
        rsp_valid  = rsp_v_q;
        rsp_code   = rsp_q;
        stage      = stage_q;
        data_ready = ready_q;
        data_size  = size_q;
        irq_setup  = irq_setup_q;
        irq_status = irq_status_q;
    end

    a_r2_setup_irq_data: assert property (@(posedge clk) disable iff (rst)
        irq_setup_q |-> (stage_q == ST_DATA && $past(last_q) == TK_SETUP));

    a_r7_ready_rise_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> (rsp_v_q && rsp_q == RS_ACK && $past(last_q) == TK_OUT));

    a_r8_status_entry: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_STATUS && $past(stage_q) == ST_DATA)
        |-> $past(cpu_eop_wr && !cpu_eop_ep0));

    a_r10_zlp_in_status: assert property (@(posedge clk) disable iff (rst)
        (rsp_v_q && rsp_q == RS_ZLP) |-> $past(stage_q) == ST_STATUS);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        irq_status_q |-> (stage_q == ST_IDLE && $past(zlp_sent_q)));

    a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_SETUP) |=> (!ready_q && stage_q == ST_SETUP));

endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
    import ep0_seq_pkg::*;
#(
    parameter int SIZE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              pkt_end,
    input  logic              pkt_err,
    input  logic              pkt_data1,
    input  logic              host_ack,
    input  logic              cpu_setup_ack,
    input  logic              cpu_eop_wr,
    input  logic              cpu_eop_ep0,
    input  logic              cpu_fifo_drained,
    input  logic              cpu_irq_clr_wr,
    input  logic [1:0]        cpu_irq_clr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [1:0]        stage,
    output logic [7:0]        req_type,
    output logic [7:0]        req_code,
    output logic [15:0]       req_value,
    output logic [15:0]       req_index,
    output logic [15:0]       req_length,
    output logic              data_ready,
    output logic [SIZE_W-1:0] data_size,
    output logic              irq_setup,
    output logic              irq_status,
    output logic [1:0]        irq_flags
);

    rsp_t                   rsp_e;
    stage_t                 stage_e;
    logic                   byte_we, commit, status_done;
    logic [SETUP_IDX_W-1:0] byte_idx;
    setup_req_t             req;
    logic [NUM_IRQ-1:0]     irq_set;

    ep0_stage_fsm #(.SIZE_W(SIZE_W)) u_fsm (
        .clk              (clk),
        .rst              (rst),
        .tok_valid        (tok_valid),
        .tok_kind         (tok_t'(tok_kind)),
        .rx_valid         (rx_valid),
        .pkt_end          (pkt_end),
        .pkt_err          (pkt_err),
        .pkt_data1        (pkt_data1),
        .host_ack         (host_ack),
        .cpu_setup_ack    (cpu_setup_ack),
        .cpu_eop_wr       (cpu_eop_wr),
        .cpu_eop_ep0      (cpu_eop_ep0),
        .cpu_fifo_drained (cpu_fifo_drained),
        .rsp_valid        (rsp_valid),
        .rsp_code         (rsp_e),
        .stage            (stage_e),
        .data_ready       (data_ready),
        .data_size        (data_size),
        .setup_byte_we    (byte_we),
        .setup_byte_idx   (byte_idx),
        .setup_commit     (commit),
        .status_done      (status_done),
        .irq_setup        (irq_setup),
        .irq_status       (irq_status)
    );

    ep0_setup_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .byte_we  (byte_we),
        .byte_idx (byte_idx),
        .byte_in  (rx_byte),
        .commit   (commit),
        .req      (req)
    );

    always_comb irq_set = {status_done, commit};

    ep0_irq_status u_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (irq_set),
        .clr_wr (cpu_irq_clr_wr),
        .clr    (cpu_irq_clr),
        .flags  (irq_flags)
    );

    always_comb begin
        rsp_code   = rsp_e;
        stage      = stage_e;
        req_type   = req.rtype;
        req_code   = req.code;
        req_value  = req.value;
        req_index  = req.index;
        req_length = req.length;
    end

endmodule

// File: tb/ep0_ctrl_seq_test.sv
module ep0_ctrl_seq_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tok_valid = 0, rx_valid = 0, pkt_end = 0, pkt_err = 0, pkt_data1 = 0;
    logic [1:0] tok_kind = 0;
    logic [7:0] rx_byte = 0;
    logic host_ack = 0, cpu_setup_ack = 0, cpu_eop_wr = 0, cpu_eop_ep0 = 0;
    logic cpu_fifo_drained = 0, cpu_irq_clr_wr = 0;
    logic [1:0] cpu_irq_clr = 0;
    logic rsp_valid, data_ready, irq_setup, irq_status;
    logic [1:0] rsp_code, stage, irq_flags;
    logic [7:0] req_type, req_code;
    logic [15:0] req_value, req_index, req_length;
    logic [6:0] data_size;

    ep0_ctrl_seq uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    // bench model
    int m_stage = 0, m_last = 3, m_size = 0, m_flags = 0;
    bit m_acked = 0, m_ready = 0, m_tog = 0, m_zlp = 0;
    logic [7:0] m_b [0:7];
    logic [7:0] pbuf [0:63];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic post(input bit ev, input int er, input bit is, input bit it);
        chk("R13 rsp_valid", 32'(rsp_valid), 32'(ev));
        if (ev) chk("R13 rsp_code", 32'(rsp_code), er);
        chk("R2 irq_setup pulse", 32'(irq_setup), 32'(is));
        chk("R10 irq_status pulse", 32'(irq_status), 32'(it));
        chk("R11 stage", 32'(stage), m_stage);
        chk("R5 data_ready", 32'(data_ready), 32'(m_ready));
        chk("R6 data_size", 32'(data_size), m_size);
        chk("R12 irq_flags", 32'(irq_flags), m_flags);
        chk("R2 req_type", 32'(req_type), 32'(m_b[0]));
        chk("R2 req_code", 32'(req_code), 32'(m_b[1]));
        chk("R2 req_value", 32'(req_value), {16'd0, m_b[3], m_b[2]});
        chk("R2 req_index", 32'(req_index), {16'd0, m_b[5], m_b[4]});
        chk("R2 req_length", 32'(req_length), {16'd0, m_b[7], m_b[6]});
    endtask

    task automatic do_token(input int k);
        bit ev = 0;
        int er = 0;
        tok_valid = 1; tok_kind = 2'(k);
        tick();
        tok_valid = 0;
        if (k == 0) begin
            m_stage = 1; m_acked = 0; m_ready = 0; m_zlp = 0; m_last = 0;
        end else if (k == 1) begin
            m_last = 1;
        end else begin
            m_last = 3; ev = 1;   // R9 / R10
            if (m_stage == 3) begin er = 2; m_zlp = 1; end
            else er = 1;
        end
        post(ev, er, 0, 0);
    endtask

    task automatic do_packet(input int n, input bit err, input bit d1, input logic [1:0] mask);
        bit ev = 0, is = 0;
        int er = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = pbuf[i];
            tick();
        end
        rx_valid = 0;
        pkt_end = 1; pkt_err = err; pkt_data1 = d1;
        cpu_irq_clr_wr = (mask != 0); cpu_irq_clr = mask;
        tick();
        pkt_end = 0; pkt_err = 0; cpu_irq_clr_wr = 0; cpu_irq_clr = 0;
        m_flags = m_flags & ~int'(mask);
        if (!err) begin
            if (m_last == 0 && m_stage == 1) begin
                if (n == 8) begin
                    ev = 1; er = 0; is = 1;
                    for (int i = 0; i < 8; i++) m_b[i] = pbuf[i];
                    m_flags |= 1; m_stage = 2; m_tog = 1;
                end
            end else if (m_last == 1) begin
                ev = 1;
                if (m_stage == 2 && m_acked && !m_ready) begin
                    er = 0;
                    if (d1 == m_tog) begin
                        m_ready = 1; m_size = n; m_tog = ~m_tog;
                    end
                end else begin
                    er = 1;
                end
            end
        end
        m_last = 3;
        post(ev, er, is, 0);
    endtask

    // kind: 0 setup ack, 1 drained, 2 eop write (arg = bit), 3 host ack, 4 flag clear (arg = mask)
    task automatic do_cpu(input int kind, input int arg);
        bit it = 0;
        case (kind)
            0: cpu_setup_ack = 1;
            1: cpu_fifo_drained = 1;
            2: begin cpu_eop_wr = 1; cpu_eop_ep0 = arg[0]; end
            3: host_ack = 1;
            default: begin cpu_irq_clr_wr = 1; cpu_irq_clr = arg[1:0]; end
        endcase
        tick();
        cpu_setup_ack = 0; cpu_fifo_drained = 0; cpu_eop_wr = 0; cpu_eop_ep0 = 0;
        host_ack = 0; cpu_irq_clr_wr = 0; cpu_irq_clr = 0;
        case (kind)
            0: if (m_stage == 2) m_acked = 1;
            1: m_ready = 0;
            2: if (!arg[0] && m_stage == 2 && m_acked) m_stage = 3;
            3: if (m_zlp && m_stage == 3) begin
                   it = 1; m_flags |= 2; m_stage = 0; m_zlp = 0;
               end
            default: m_flags = m_flags & ~(arg & 3);
        endcase
        post(0, 0, 0, it);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) pbuf[i] = 8'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) m_b[i] = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        tick();
        post(0, 0, 0, 0);  // R1 reset state

        // directed full control-write transfer
        do_token(2);                   // R9 IN while idle -> NAK
        do_token(0); fill(8); do_packet(8, 0, 0, 2'b00);   // R2
        do_token(1); fill(4); do_packet(4, 0, 1, 2'b00);   // R4 NAK before ack
        do_token(2);                   // R9 IN in data stage
        do_cpu(0, 0);
        do_token(1); fill(5); do_packet(5, 0, 0, 2'b00);   // R6 wrong toggle
        do_token(1); fill(64); do_packet(64, 0, 1, 2'b00); // R5 DATA1, full size
        do_token(1); fill(3); do_packet(3, 0, 0, 2'b00);   // R7 NAK while ready
        do_cpu(1, 0);                                      // R7 drain
        do_token(1); do_packet(0, 0, 0, 2'b00);            // R5 zero-length DATA0
        do_cpu(1, 0);
        do_token(1); fill(6); do_packet(6, 1, 1, 2'b00);   // R3 errored OUT
        do_cpu(2, 1);                  // R8 bit 1 ignored
        do_token(2);                   // R9 IN before eop
        do_cpu(2, 0);                  // R8 to status
        do_cpu(3, 0);                  // R10 stray host ack
        do_token(2);                   // R10 ZLP
        do_cpu(3, 0);                  // R10 done
        do_cpu(4, 1);                  // R12 clear bit 0
        do_token(0); fill(7); do_packet(7, 0, 0, 2'b00);   // R3 short setup
        do_token(0); fill(8); do_packet(8, 1, 0, 2'b00);   // R3 errored setup
        do_token(0); fill(8); do_packet(8, 0, 0, 2'b01);   // R12 set beats clear
        do_cpu(0, 0);
        do_token(1); fill(9); do_packet(9, 0, 1, 2'b00);
        do_token(0);                   // R11 abort with data waiting
        fill(8); do_packet(8, 0, 0, 2'b11);

        // constrained random
        for (int it = 0; it < 2500; it++) begin
            int r = int'($urandom % 16);
            if (r < 2) begin
                int n = ($urandom % 8 == 0) ? 7 : 8;
                do_token(0); fill(n);
                do_packet(n, ($urandom % 10) == 0, 0, 2'($urandom));
            end else if (r < 6) begin
                int n = int'($urandom % 65);
                bit d1 = ($urandom % 5 == 0) ? ~m_tog : m_tog;
                do_token(1); fill(n);
                do_packet(n, ($urandom % 16) == 0, d1, 2'b00);
            end else if (r < 8) do_token(2);
            else if (r < 10) do_cpu(0, 0);
            else if (r < 11) do_cpu(1, 0);
            else if (r < 13) do_cpu(2, ($urandom % 5) == 0);
            else if (r < 15) do_cpu(3, 0);
            else do_cpu(4, int'($urandom % 4));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule